// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This block sits next to the decode stage of a simple in-order processor and watches for two faults. The first is an undefined opcode that is not in a delay slot. The second is any bad instruction that sits in the slot after a delayed branch: an undefined opcode there, or a valid instruction that writes the program counter. When the decoder flags either case, the block stalls the decoder and runs the exception entry steps through a single memory port. It pushes the status word, then pushes a return address, then reads the handler address from the vector table and hands it out as the new PC, together with the lowered stack pointer.

The two classes differ in two ways: the vector they use and the return address they save. A fault in a slot saves the target of the delayed branch that owns the slot. A general fault saves the address of the undefined instruction itself. The jump to the handler takes effect in the cycle the new PC is loaded and has no delay slot. Each memory access is held on the port until the memory acknowledges it, so slow memories are handled.

Top module: `illx_seq`

## Requirements
- R1: When `dec_valid` is high, `dec_in_slot` is high and `dec_undef` is high, a slot exception starts. The second push writes `dec_slot_tgt`, and the vector read uses index 6.
- R2: When `dec_valid` and `dec_in_slot` are high and `dec_pc_write` is high while `dec_undef` is low, a slot exception also starts, with the same pushed address and vector as R1.
- R3: When `dec_valid` and `dec_undef` are high and `dec_in_slot` is low, a general exception starts. The second push writes `dec_pc`, and the vector read uses index 4.
- R4: The first access is a write of `cur_sr` to address `cur_sp`-4. The second is a write of the return address to `cur_sp`-8. At the end, `new_sp` equals `cur_sp`-8.
- R5: The third access is a read (`mem_we`=0) from `vec_base` + 4×index. The word read back appears on `new_pc` while `pc_load` and `sp_load` are high for exactly one cycle. `busy` is low in the cycle after that.
- R6: An instruction in a slot with both `dec_undef` and `dec_pc_write` set starts a single slot exception, with exactly three memory accesses.
- R7: `busy` is high from the cycle after a fault is accepted until the cycle in which `pc_load` is high. Decode inputs that arrive while `busy` is high have no effect.
- R8: An access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the clock edge at which `mem_ack` is high, and it completes at that edge.
- R9: After reset, `busy`, `mem_req`, `pc_load` and `sp_load` are low.
- R10: No exception starts when `dec_valid` is low, or when `dec_pc_write` is set outside a slot with `dec_undef` low. In those cases no memory access is made and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction this cycle |
| dec_undef | input | 1 | The opcode is undefined |
| dec_pc_write | input | 1 | The instruction writes the PC |
| dec_in_slot | input | 1 | The instruction sits in a delayed-branch slot |
| dec_pc | input | 32 | Address of the decoded instruction |
| dec_slot_tgt | input | 32 | Target of the pending delayed branch |
| cur_sr | input | 32 | Current status register |
| cur_sp | input | 32 | Current stack pointer |
| vec_base | input | 32 | Base address of the vector table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this clock edge |
| busy | output | 1 | Stall request to the decoder |
| pc_load | output | 1 | One-cycle strobe to load `new_pc` |
| new_pc | output | 32 | Handler start address |
| sp_load | output | 1 | One-cycle strobe to load `new_sp` |
| new_sp | output | 32 | Stack pointer after the two pushes |

## Verification
The assertions assume three things about the environment. First, `cur_sp` and `vec_base` are word aligned, so every access address has its two low bits clear. Second, `mem_ack` is raised only while `mem_req` is high. Third, the decoder presents a fault for one cycle and does not count on it being taken while `busy` is high. The stimulus uses only aligned stack and table addresses. Its memory model raises the acknowledge only against a pending request, after a selectable number of wait cycles. One scenario deliberately keeps a second fault on the decode inputs for the whole time `busy` is high, to check that it is ignored.

// File: rtl/illx_pkg.sv
package illx_pkg;

    localparam int unsigned XLEN        = 32;
    localparam int unsigned WORD_BYTES  = XLEN / 8;
    localparam int unsigned VEC_GENERAL = 4;
    localparam int unsigned VEC_SLOT    = 6;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_FETCH_VEC,
        ST_JUMP
    } seq_state_t;

    typedef enum logic {
        EXC_GENERAL = 1'b0,
        EXC_SLOT    = 1'b1
    } exc_class_t;

    // Context captured when a fault is accepted.
    typedef struct packed {
        exc_class_t cls;
        word_t      ret_pc;
        word_t      sr;
        word_t      sp;
        word_t      vec_addr;
    } exc_ctx_t;

    function automatic word_t vector_address(word_t base, exc_class_t c);
        int unsigned idx;
        idx = (c == EXC_SLOT) ? VEC_SLOT : VEC_GENERAL;
        return base + word_t'(idx * WORD_BYTES);
    endfunction

endpackage

// File: rtl/illx_classify.sv
module illx_classify
    import illx_pkg::*;
(
    input  logic       valid,
    input  logic       undef,
    input  logic       pc_write,
    input  logic       in_slot,
    input  word_t      insn_pc,
    input  word_t      branch_tgt,
    output logic       hit,
    output exc_class_t cls,
    output word_t      ret_pc
);
    logic slot_bad;
    logic gen_bad;

    always_comb begin
        // A slot instruction with both flags still gives one slot fault.
        slot_bad = in_slot & (undef | pc_write);
        gen_bad  = ~in_slot & undef;
        hit      = valid & (slot_bad | gen_bad);
        cls      = slot_bad ? EXC_SLOT : EXC_GENERAL;
        ret_pc   = slot_bad ? branch_tgt : insn_pc;
    end
endmodule

// File: rtl/illx_fsm.sv
module illx_fsm
    import illx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  exc_ctx_t ctx_in,
    input  logic     mem_ack,
    input  word_t    mem_rdata,
    output logic     busy,
    output logic     mem_req,
    output logic     mem_we,
    output word_t    mem_addr,
    output word_t    mem_wdata,
    output logic     pc_load,
    output word_t    new_pc,
    output logic     sp_load,
    output word_t    new_sp
);
    seq_state_t state_q;
    exc_ctx_t   ctx_q;
    word_t      handler_q;
    word_t      sp_dec;

    assign sp_dec = ctx_q.sp - word_t'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            handler_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctx_q   <= ctx_in;
                        state_q <= ST_PUSH_SR;
                    end
                end
                ST_PUSH_SR: begin
                    if (mem_ack) begin
                        ctx_q.sp <= sp_dec;
                        state_q  <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: begin
                    if (mem_ack) begin
                        ctx_q.sp <= sp_dec;
                        state_q  <= ST_FETCH_VEC;
                    end
                end
                ST_FETCH_VEC: begin
                    if (mem_ack) begin
                        handler_q <= mem_rdata;
                        state_q   <= ST_JUMP;
                    end
                end
                ST_JUMP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        sp_load   = 1'b0;
        new_pc    = handler_q;
        new_sp    = ctx_q.sp;
        unique case (state_q)
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = ctx_q.sr;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = ctx_q.ret_pc;
            end
            ST_FETCH_VEC: begin
                mem_req   = 1'b1;
                mem_addr  = ctx_q.vec_addr;
            end
            ST_JUMP: begin
                pc_load   = 1'b1;
                sp_load   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/illx_seq.sv
module illx_seq
    import illx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dec_valid,
    input  logic        dec_undef,
    input  logic        dec_pc_write,
    input  logic        dec_in_slot,
    input  logic [31:0] dec_pc,
    input  logic [31:0] dec_slot_tgt,
    input  logic [31:0] cur_sr,
    input  logic [31:0] cur_sp,
    input  logic [31:0] vec_base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        busy,
    output logic        pc_load,
    output logic [31:0] new_pc,
    output logic        sp_load,
    output logic [31:0] new_sp
);
    logic       hit;
    exc_class_t cls;
    word_t      ret_pc;
    exc_ctx_t   ctx;
    logic       start;

    illx_classify u_classify (
        .valid      (dec_valid),
        .undef      (dec_undef),
        .pc_write   (dec_pc_write),
        .in_slot    (dec_in_slot),
        .insn_pc    (dec_pc),
        .branch_tgt (dec_slot_tgt),
        .hit        (hit),
        .cls        (cls),
        .ret_pc     (ret_pc)
    );

    always_comb begin
        ctx.cls      = cls;
        ctx.ret_pc   = ret_pc;
        ctx.sr       = cur_sr;
        ctx.sp       = cur_sp;
        ctx.vec_addr = vector_address(vec_base, cls);
    end

    // Decode inputs are ignored while a sequence is running.
    assign start = hit & ~busy;

    illx_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ctx_in    (ctx),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .pc_load   (pc_load),
        .new_pc    (new_pc),
        .sp_load   (sp_load),
        .new_sp    (new_sp)
    );
endmodule

// File: rtl/illx_seq_chk.sv
module illx_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        dec_valid,
    input logic        dec_undef,
    input logic        dec_pc_write,
    input logic        dec_in_slot,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        busy,
    input logic        pc_load,
    input logic        sp_load
);
    logic fault_in;
    assign fault_in = dec_valid &&
                      ((dec_in_slot && (dec_undef || dec_pc_write)) ||
                       (!dec_in_slot && dec_undef));

    // R7: an accepted fault raises busy and starts with a push
    assert_enter_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && fault_in) |=> (busy && mem_req && mem_we));

    // R10: without a fault the block stays idle
    assert_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !fault_in) |=> !busy);

    // R9: an idle block drives nothing
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !pc_load && !sp_load));

    // R8: a pending access holds its fields
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R4: stack and table accesses are word aligned
    assert_align_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R5: the completed vector read is followed by the load strobe
    assert_read_then_load_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we) |=> (pc_load && sp_load));

    // R5: the load strobe lasts one cycle and ends the sequence
    assert_load_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> (!pc_load && !busy));
endmodule

bind illx_seq illx_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_valid    (dec_valid),
    .dec_undef    (dec_undef),
    .dec_pc_write (dec_pc_write),
    .dec_in_slot  (dec_in_slot),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .busy         (busy),
    .pc_load      (pc_load),
    .sp_load      (sp_load)
);

// File: tb/tb_illx_seq.sv
module tb_illx_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER_MASK = 32'hC0DE_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 0, dec_undef = 0, dec_pc_write = 0, dec_in_slot = 0;
    logic [31:0] dec_pc = '0, dec_slot_tgt = '0, cur_sr = '0, cur_sp = '0, vec_base = '0;
    logic        mem_req, mem_we, mem_ack, busy, pc_load, sp_load;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_sp;

    int checks = 0;
    int fails  = 0;
    int wait_cycles = 0;
    int wcnt = 0;

    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];
    int          log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    illx_seq dut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_undef(dec_undef), .dec_pc_write(dec_pc_write),
        .dec_in_slot(dec_in_slot), .dec_pc(dec_pc), .dec_slot_tgt(dec_slot_tgt),
        .cur_sr(cur_sr), .cur_sp(cur_sp), .vec_base(vec_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .pc_load(pc_load), .new_pc(new_pc),
        .sp_load(sp_load), .new_sp(new_sp)
    );

    // Memory model: acknowledge after wait_cycles, reads return addr ^ mask.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= wait_cycles) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_addr ^ HANDLER_MASK;
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // Log each access at the edge where it completes.
    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            log_addr[log_n % 64] <= mem_addr;
            log_data[log_n % 64] <= mem_wdata;
            log_we[log_n % 64]   <= mem_we;
            log_n                <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // One fault scenario. inject keeps a second fault on the inputs while busy.
    task automatic run_fault(input string req, input bit undef, input bit pcw, input bit slot,
                             input logic [31:0] pc, input logic [31:0] tgt,
                             input logic [31:0] sr, input logic [31:0] sp,
                             input logic [31:0] vb, input int wt, input bit inject);
        int base;
        bit seen;
        logic [31:0] exp_ret, exp_vaddr, got_pc, got_sp;
        logic got_spl;
        bit is_slot;
        is_slot   = slot && (undef || pcw);
        exp_ret   = is_slot ? tgt : pc;
        exp_vaddr = vb + (is_slot ? 32'd24 : 32'd16);
        wait_cycles = wt;
        @(negedge clk);
        base = log_n;
        dec_valid = 1; dec_undef = undef; dec_pc_write = pcw; dec_in_slot = slot;
        dec_pc = pc; dec_slot_tgt = tgt; cur_sr = sr; cur_sp = sp; vec_base = vb;
        @(negedge clk);
        if (inject) begin
            dec_undef = 1; dec_pc_write = 0; dec_in_slot = 0;
            dec_pc = pc + 32'h100; cur_sr = ~sr; cur_sp = sp - 32'h40; vec_base = vb + 32'h80;
        end else begin
            dec_valid = 0; dec_undef = 0; dec_pc_write = 0; dec_in_slot = 0;
        end
        chk(busy === 1'b1, "R7", {req, " busy after accept"}, {31'd0, busy}, 32'd1);
        seen = 0;
        got_pc = '0; got_sp = '0; got_spl = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (pc_load === 1'b1) begin
                seen = 1; got_pc = new_pc; got_sp = new_sp; got_spl = sp_load;
                chk(busy === 1'b1, "R7", {req, " busy during load"}, {31'd0, busy}, 32'd1);
            end else begin
                @(negedge clk);
            end
        end
        dec_valid = 0; dec_undef = 0; dec_pc_write = 0; dec_in_slot = 0;
        chk(seen, "R5", {req, " pc_load seen"}, {31'd0, seen}, 32'd1);
        chk(got_spl === 1'b1, "R5", {req, " sp_load with pc_load"}, {31'd0, got_spl}, 32'd1);
        chk(log_n - base == 3, "R6", {req, " access count"}, 32'(log_n - base), 32'd3);
        chk(log_we[base % 64] === 1'b1 && log_addr[base % 64] === sp - 32'd4,
            "R4", {req, " SR push address"}, log_addr[base % 64], sp - 32'd4);
        chk(log_data[base % 64] === sr, "R4", {req, " SR push data"}, log_data[base % 64], sr);
        chk(log_we[(base+1) % 64] === 1'b1 && log_addr[(base+1) % 64] === sp - 32'd8,
            "R4", {req, " PC push address"}, log_addr[(base+1) % 64], sp - 32'd8);
        chk(log_data[(base+1) % 64] === exp_ret, req, "pushed return address",
            log_data[(base+1) % 64], exp_ret);
        chk(log_we[(base+2) % 64] === 1'b0 && log_addr[(base+2) % 64] === exp_vaddr,
            "R5", {req, " vector read address"}, log_addr[(base+2) % 64], exp_vaddr);
        chk(got_pc === (exp_vaddr ^ HANDLER_MASK), "R5", {req, " handler PC"},
            got_pc, exp_vaddr ^ HANDLER_MASK);
        chk(got_sp === sp - 32'd8, "R4", {req, " final SP"}, got_sp, sp - 32'd8);
        @(negedge clk);
        chk(busy === 1'b0 && pc_load === 1'b0, "R5", {req, " released after load"},
            {30'd0, busy, pc_load}, 32'd0);
    endtask

    // A stimulus that must not start a sequence.
    task automatic run_quiet(input string req, input bit valid, input bit undef,
                             input bit pcw, input bit slot);
        int base;
        bit any;
        @(negedge clk);
        base = log_n;
        dec_valid = valid; dec_undef = undef; dec_pc_write = pcw; dec_in_slot = slot;
        dec_pc = 32'h0000_2000; cur_sp = 32'h0000_8000; vec_base = 32'h0;
        @(negedge clk);
        dec_valid = 0; dec_undef = 0; dec_pc_write = 0; dec_in_slot = 0;
        any = 0;
        for (int i = 0; i < 10; i++) begin
            if (busy !== 1'b0 || mem_req !== 1'b0 || pc_load !== 1'b0) any = 1;
            @(negedge clk);
        end
        chk(!any, req, "no activity", {31'd0, any}, 32'd0);
        chk(log_n == base, req, "no memory access", 32'(log_n - base), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state
        chk(busy === 1'b0 && mem_req === 1'b0 && pc_load === 1'b0 && sp_load === 1'b0,
            "R9", "reset state", {28'd0, busy, mem_req, pc_load, sp_load}, 32'd0);
        // R3: general undefined opcode
        run_fault("R3", 1, 0, 0, 32'h0000_1234, 32'h0000_5550, 32'h0000_00F1,
                  32'h0000_8000, 32'h0000_0000, 0, 0);
        // R1: undefined opcode in slot
        run_fault("R1", 1, 0, 1, 32'h0000_3002, 32'h0000_7700, 32'h0000_0302,
                  32'h0001_0000, 32'h0004_0000, 0, 0);
        // R2: PC-writing valid opcode in slot
        run_fault("R2", 0, 1, 1, 32'h0000_4006, 32'h0000_9AB0, 32'hA5A5_0003,
                  32'h0000_F000, 32'h0000_1000, 0, 0);
        // R6: both flags in slot
        run_fault("R6", 1, 1, 1, 32'h0000_500A, 32'h0000_1230, 32'h1234_5678,
                  32'h0000_C000, 32'h0000_2000, 0, 0);
        // R10: PC write outside slot, and invalid decode
        run_quiet("R10", 1, 0, 1, 0);
        run_quiet("R10", 0, 1, 0, 0);
        // R8: slow memory with wait cycles
        run_fault("R8", 1, 0, 1, 32'h0000_6000, 32'h0000_6ABC, 32'h0000_0077,
                  32'h0002_0000, 32'h0000_3000, 3, 0);
        // R7: fault held on inputs while busy is ignored
        run_fault("R7", 1, 0, 0, 32'h0000_7010, 32'h0000_0000, 32'h0000_0055,
                  32'h0000_A000, 32'h0000_4000, 1, 1);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule